// File: doc/BRIEF.md
# Audio bit and frame clock generator

This block derives the serial bit clock of an audio port from a master audio clock, and the frame (left/right) clock from that bit clock. Both rates are set by integer divider inputs. All logic runs on the master clock: the two outputs are registered levels that toggle on master clock edges, so they reach the pad without glitches.

The block also works out whether the frame clock pad is driven. A master port drives it once any playback or record channel is enabled. A slave port leaves the pad undriven unless one of two direction-force bits asks for it, which lets one direction act as master while the other is slave. When record traffic has its own separate frame clock pin, record-side enables and the record force bit no longer affect the main pad. While the pad is not driven, the frame divider is held idle. When the pad is driven again, the frame divider restarts with a whole first frame.

Top module: `aclk_gen`

## Requirements
- R1: `bclk_o` has a period of `bdiv_i` master clock cycles, with a high phase of floor(`bdiv_i`/2) cycles. An odd setting therefore gives a high phase one cycle shorter than the low phase.
- R2: While the frame clock is enabled, `fclk_o` has a period of `fdiv_i` bit clock periods, with a high phase of floor(`fdiv_i`/2) bit clock periods.
- R3: Every rising edge of `fclk_o` occurs on the same master clock cycle as a rising edge of `bclk_o`.
- R4: A divider setting of 0 or 1 behaves as a setting of 2.
- R5: While frames are running, a change on `bdiv_i` or `fdiv_i` leaves the current frame at its old length and takes effect from the next frame start.
- R6: In master mode (`master_i`=1) with `alt_rec_pin_i`=0, `fclk_oe_o` is 1 when any bit of `play_en_i` or `rec_en_i` is 1.
- R7: With `alt_rec_pin_i`=1, `rec_en_i` and `force_rec_i` have no effect on `fclk_oe_o` or on `fclk_o`.
- R8: In slave mode (`master_i`=0), `fclk_oe_o` is 0 and `fclk_o` stays low unless a force bit that is allowed to act is set.
- R9: `force_play_i`=1 sets `fclk_oe_o` in either mode. `force_rec_i`=1 does the same when `alt_rec_pin_i`=0.
- R10: When `fclk_oe_o` falls, `fclk_o` is low from the next master clock cycle. When `fclk_oe_o` rises again, the first frame starts on a bit clock rising edge and has a full high phase and a full period.
- R11: During reset, `bclk_o`, `fclk_o` and (with all control inputs at 0) `fclk_oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | master audio clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| master_i | input | 1 | 1 = port is clock master, 0 = slave |
| alt_rec_pin_i | input | 1 | record side uses its own frame clock pin |
| play_en_i | input | NCH | playback channel enables |
| rec_en_i | input | NCH | record channel enables |
| force_play_i | input | 1 | force frame clock output, playback direction |
| force_rec_i | input | 1 | force frame clock output, record direction |
| bdiv_i | input | BDIV_W | bit clock divide ratio (master cycles per bit) |
| fdiv_i | input | FDIV_W | frame divide ratio (bits per frame) |
| bclk_o | output | 1 | bit clock |
| fclk_o | output | 1 | frame clock |
| fclk_oe_o | output | 1 | frame clock pad output enable |

## Verification
The bench sweeps every divider pair in a small range, including odd ratios. A design with the wrong phase split would show a high phase equal to the low phase or longer than it. A settings change is made just after a frame edge. A divider that loads at once would cut that frame short, or produce a runt pulse. Every combination of mode, pin option, enables and force bits is applied to the output enable. At the pins, the bench checks that ignored record inputs never bring up the frame clock. Finally, the bench disables and re-enables the frame clock. A counter that is not cleared in between would restart mid-frame, with a clipped first high phase.

// File: rtl/aclk_pkg.sv
`timescale 1ns/1ps
package aclk_pkg;
  localparam int unsigned MIN_DIV = 2;

  typedef struct packed {
    logic master;
    logic alt_pin;
    logic play_any;
    logic rec_any;
    logic force_play;
    logic force_rec;
  } oe_req_t;
endpackage

// File: rtl/aclk_oe_ctrl.sv
`timescale 1ns/1ps
module aclk_oe_ctrl
  import aclk_pkg::*;
(
  input  oe_req_t req_i,
  output logic    oe_o
);
  logic rec_ok;

  always_comb begin
    rec_ok = !req_i.alt_pin;
    oe_o   = req_i.force_play
           | (rec_ok & req_i.force_rec)
           | (req_i.master & (req_i.play_any | (rec_ok & req_i.rec_any)));
  end

  always_comb begin
    if (!req_i.master && !req_i.force_play && !req_i.force_rec)
      AST_SLAVE_QUIET: assert (!oe_o); // R8
    if (req_i.alt_pin && !req_i.play_any && !req_i.force_play)
      AST_ALT_REC_IGNORED: assert (!oe_o); // R7
    if (req_i.force_play)
      AST_FORCE_PLAY: assert (oe_o); // R9
  end
endmodule

// File: rtl/aclk_bit_div.sv
`timescale 1ns/1ps
module aclk_bit_div
  import aclk_pkg::*;
#(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] div_i,
  input  logic         load_i,
  output logic         bclk_o,
  output logic         wrap_o,
  output logic [W-1:0] act_o
);
  localparam logic [W-1:0] DMIN = W'(MIN_DIV);

  logic [W-1:0] cnt_q, cnt_n, act_q, act_n;
  logic         bclk_q;

  function automatic logic [W-1:0] clamp(input logic [W-1:0] d);
    return (d < DMIN) ? DMIN : d;
  endfunction

  always_comb begin
    wrap_o = (cnt_q == act_q - W'(1));
    cnt_n  = wrap_o ? '0 : cnt_q + W'(1);
    act_n  = (wrap_o && load_i) ? clamp(div_i) : act_q;
  end

  // count resets to last slot so the first edge loads the setting
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= DMIN - W'(1);
      act_q  <= DMIN;
      bclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      act_q  <= act_n;
      bclk_q <= (cnt_n < (act_n >> 1));
    end
  end

  assign bclk_o = bclk_q;
  assign act_o  = act_q;

  AST_BCLK_RISE_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bclk_q) |-> (cnt_q == '0)); // R1
  AST_BIT_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < act_q); // R1
  AST_BIT_DIV_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q >= DMIN); // R4
endmodule

// File: rtl/aclk_frame_div.sv
`timescale 1ns/1ps
module aclk_frame_div
  import aclk_pkg::*;
#(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic [W-1:0] div_i,
  output logic         fclk_o,
  output logic         run_o,
  output logic         last_o
);
  localparam logic [W-1:0] DMIN = W'(MIN_DIV);

  logic [W-1:0] cnt_q, act_q, cnt_inc;
  logic         run_q, fclk_q;

  function automatic logic [W-1:0] clamp(input logic [W-1:0] d);
    return (d < DMIN) ? DMIN : d;
  endfunction

  always_comb begin
    last_o  = run_q && (cnt_q == act_q - W'(1));
    cnt_inc = cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      act_q  <= DMIN;
      fclk_q <= 1'b0;
    end else if (!en_i) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      act_q  <= clamp(div_i);
      fclk_q <= 1'b0;
    end else if (tick_i) begin
      if (!run_q || last_o) begin
        // frame start: ratio is at least 2, so the high phase is non-empty
        run_q  <= 1'b1;
        cnt_q  <= '0;
        act_q  <= clamp(div_i);
        fclk_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_inc;
        fclk_q <= (cnt_inc < (act_q >> 1));
      end
    end
  end

  assign fclk_o = fclk_q;
  assign run_o  = run_q;

  AST_FCLK_LOW_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !fclk_q); // R10
  AST_FCLK_MOVES_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$stable(fclk_q)) |-> $past(tick_i)); // R2
  AST_FRAME_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < act_q); // R2
endmodule

// File: rtl/aclk_gen.sv
`timescale 1ns/1ps
module aclk_gen
  import aclk_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned BDIV_W = 6,
  parameter int unsigned FDIV_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              alt_rec_pin_i,
  input  logic [NCH-1:0]    play_en_i,
  input  logic [NCH-1:0]    rec_en_i,
  input  logic              force_play_i,
  input  logic              force_rec_i,
  input  logic [BDIV_W-1:0] bdiv_i,
  input  logic [FDIV_W-1:0] fdiv_i,
  output logic              bclk_o,
  output logic              fclk_o,
  output logic              fclk_oe_o
);
  oe_req_t           req;
  logic              oe;
  logic              bwrap, bload;
  logic [BDIV_W-1:0] bact;
  logic              frun, flast;

  always_comb begin
    req.master     = master_i;
    req.alt_pin    = alt_rec_pin_i;
    req.play_any   = |play_en_i;
    req.rec_any    = |rec_en_i;
    req.force_play = force_play_i;
    req.force_rec  = force_rec_i;
  end

  aclk_oe_ctrl u_oe (
    .req_i (req),
    .oe_o  (oe)
  );

  // bit ratio may only change on a frame edge once frames are running
  assign bload = !frun || flast;

  aclk_bit_div #(.W(BDIV_W)) u_bit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (bdiv_i),
    .load_i (bload),
    .bclk_o (bclk_o),
    .wrap_o (bwrap),
    .act_o  (bact)
  );

  aclk_frame_div #(.W(FDIV_W)) u_frm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (oe),
    .tick_i (bwrap),
    .div_i  (fdiv_i),
    .fclk_o (fclk_o),
    .run_o  (frun),
    .last_o (flast)
  );

  assign fclk_oe_o = oe;

  AST_FRAME_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fclk_o) |-> $rose(bclk_o)); // R3
  AST_BDIV_AT_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frun && $past(frun) && !$stable(bact)) |-> $past(flast && bwrap)); // R5
  AST_NO_FCLK_WITHOUT_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fclk_o |-> $past(oe)); // R10
endmodule

// File: tb/sim_aclk_gen.sv
`timescale 1ns/1ps
module sim_aclk_gen;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           master = 1'b0, alt = 1'b0, fp = 1'b0, fr = 1'b0;
  logic [NCH-1:0] play_en = '0, rec_en = '0;
  logic [5:0]     bdiv = 6'd2;
  logic [8:0]     fdiv = 9'd2;
  logic           bclk, fclk, oe;
  int             total = 0, bad = 0;

  always #2 clk = ~clk;

  aclk_gen #(.NCH(NCH), .BDIV_W(6), .FDIV_W(9)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .master_i(master), .alt_rec_pin_i(alt),
    .play_en_i(play_en), .rec_en_i(rec_en), .force_play_i(fp), .force_rec_i(fr),
    .bdiv_i(bdiv), .fdiv_i(fdiv), .bclk_o(bclk), .fclk_o(fclk), .fclk_oe_o(oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit sig(input int sel);
    return (sel != 0) ? fclk : bclk;
  endfunction

  task automatic wait_rise(input int sel, output bit brose);
    bit prev = sig(sel);
    bit pb = bclk;
    brose = 0;
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if (sig(sel) && !prev) begin
        brose = bclk && !pb;
        return;
      end
      prev = sig(sel);
      pb = bclk;
    end
    chk(0, "timeout waiting for edge", 0, 1);
  endtask

  task automatic span(input int sel, output int per, output int hi);
    bit prev = 1;
    per = 1;
    hi = 1;
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if (sig(sel) && !prev) return;
      per++;
      if (sig(sel)) hi++;
      prev = sig(sel);
    end
    chk(0, "timeout measuring period", per, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int per, hi;
    bit br;
    repeat (2) @(negedge clk);
    chk(bclk == 0 && fclk == 0 && oe == 0, "R11 reset outputs", {bclk, fclk, oe}, 0);
    rst_ni = 1'b1;

    // R1 R2 R3 divider sweep in master mode
    master = 1'b1;
    play_en = 4'b0001;
    for (int b = 2; b <= 6; b++) begin
      for (int f = 2; f <= 5; f++) begin
        bdiv = 6'(b);
        fdiv = 9'(f);
        repeat (3) wait_rise(1, br);
        span(1, per, hi);
        chk(per == b * f, "R2 frame period", per, b * f);
        chk(hi == (f / 2) * b, "R2 frame high", hi, (f / 2) * b);
        wait_rise(0, br);
        span(0, per, hi);
        chk(per == b, "R1 bit period", per, b);
        chk(hi == b / 2, "R1 bit high", hi, b / 2);
        wait_rise(1, br);
        chk(br, "R3 frame edge on bit edge", br, 1);
      end
    end

    // R4 ratios below two
    for (int v = 0; v < 2; v++) begin
      bdiv = 6'(v);
      fdiv = 9'(v);
      repeat (3) wait_rise(1, br);
      span(1, per, hi);
      chk(per == 4 && hi == 2, "R4 frame at minimum ratio", per, 4);
      wait_rise(0, br);
      span(0, per, hi);
      chk(per == 2 && hi == 1, "R4 bit at minimum ratio", per, 2);
    end

    // R5 change just after a frame edge
    bdiv = 6'd4;
    fdiv = 9'd3;
    repeat (3) wait_rise(1, br);
    bdiv = 6'd2;
    fdiv = 9'd2;
    span(1, per, hi);
    chk(per == 12 && hi == 4, "R5 current frame keeps old ratio", per, 12);
    span(1, per, hi);
    chk(per == 4 && hi == 2, "R5 next frame uses new ratio", per, 4);

    // R10 disable then restart
    bdiv = 6'd3;
    fdiv = 9'd4;
    repeat (3) wait_rise(1, br);
    @(negedge clk);
    play_en = '0;
    @(negedge clk);
    chk(fclk == 0 && oe == 0, "R10 frame clock low after disable", fclk, 0);
    repeat (7) @(negedge clk);
    play_en = 4'b0100;
    wait_rise(1, br);
    chk(br, "R10 restart on bit edge", br, 1);
    span(1, per, hi);
    chk(per == 12 && hi == 6, "R10 full first frame", hi, 6);

    // R8 slave with no force: pin stays low
    master = 1'b0;
    per = 0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (fclk || oe) per++;
    end
    chk(per == 0, "R8 slave frame clock quiet", per, 0);

    // R7 record inputs ignored with separate pin
    master = 1'b1;
    alt = 1'b1;
    play_en = '0;
    rec_en = 4'b1111;
    fr = 1'b1;
    per = 0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (fclk || oe) per++;
    end
    chk(per == 0, "R7 record side ignored", per, 0);

    // R6 R7 R8 R9 exhaustive output-enable table
    for (int i = 0; i < 64; i++) begin
      bit m, a, pa, ra, xp, xr, exp;
      string tag;
      @(negedge clk);
      m  = i[0];
      a  = i[1];
      pa = i[2];
      ra = i[3];
      xp = i[4];
      xr = i[5];
      master  = m;
      alt     = a;
      play_en = pa ? 4'(1 << (i % 4)) : '0;
      rec_en  = ra ? 4'(1 << ((i + 1) % 4)) : '0;
      fp      = xp;
      fr      = xr;
      #1;
      exp = xp | (!a & xr) | (m & (pa | (!a & ra)));
      if (a) tag = "R7 oe with separate record pin";
      else if (xp || xr) tag = "R9 oe forced";
      else if (!m) tag = "R8 oe in slave";
      else tag = "R6 oe in master";
      chk(oe == exp, tag, oe, exp);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule